// File: doc/BRIEF.md
# Private Interrupt Pending Source

This block turns two kinds of event into pending bits for the 32 private interrupts of one processor. Sixteen private peripheral input lines drive interrupt IDs 16 to 31. Software-generated interrupt requests drive IDs 0 to 15. The block keeps a registered copy of every input line. A line configured as edge-triggered latches its pending bit on a rising transition. A line configured as level-triggered latches nothing; its pending status is simply the stored level.

A software request carries an interrupt ID, a requested group and a non-secure flag. The request passes through a gate before it may set pending. The gate first resolves the group, then matches it against the interrupt's configured group. When security is enabled, it also checks a non-secure request against that interrupt's 2-bit access level.

The configuration arrives as plain inputs from a register bank elsewhere: group bits, group modifier bits, trigger bits, access levels and a security-disable flag. The block outputs three things:
- a one-cycle pending-set strobe vector;
- the latched-or-level pending status;
- the stored line levels.

A clear vector from the register side drops latched pending bits. A set arriving in the same cycle wins over a clear.

Top module: `priv_pend_src`

## Requirements
- R1: The stored level of each peripheral line (output `line_level` bits 31:16, bits 15:0 always 0) takes the line's input value on every clock edge. A line whose input equals its stored level produces no pending-set strobe.
- R2: A 0-to-1 change on a peripheral line whose `cfg_edge` bit is 1 raises that interrupt's `pend_set` bit for exactly one cycle, in the cycle after the edge is sampled. The same edge latches its bit in `pend_status`, and the bit stays latched until cleared.
- R3: A peripheral line whose `cfg_edge` bit is 0 never raises `pend_set` and latches nothing. Its `pend_status` bit equals its stored level.
- R4: The configured group of interrupt i comes from two bits. If `cfg_grp[i]`=1, the group is non-secure group 1. If `cfg_grp[i]`=0 and `cfg_grpmod[i]`=1, the group is secure group 1. If both are 0, the group is group 0. Requested groups are encoded 2'b00 group 0, 2'b01 secure group 1, 2'b10 non-secure group 1.
- R5: A secure-group-1 request aimed at a group 0 interrupt is handled as a group 0 request. After this substitution, any request whose group differs from the configured group is dropped.
- R6: With `sec_off`=0, the gate checks a non-secure request against the access field in `cfg_nsacc[2i+1:2i]`. A request to a group 0 interrupt is dropped when the field is below 1. A request to a secure group 1 interrupt is dropped when the field is below 2. A request to a non-secure group 1 interrupt is not checked.
- R7: An accepted software request raises exactly its own `pend_set` bit for one cycle, one cycle after the request, and latches that bit in `pend_status`.
- R8: With `sec_off`=1, the access field is not consulted at all.
- R9: When a set and a `pend_clr` bit for the same interrupt land in the same cycle, the interrupt stays pending. A peripheral edge and a software request in the same cycle both take effect.
- R10: After reset, `pend_set`, `pend_status` and `line_level` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ppi_in | input | 16 | Peripheral input lines for IDs 16..31 |
| sgi_valid | input | 1 | Software request strobe |
| sgi_id | input | 4 | Requested interrupt ID 0..15 |
| sgi_grp | input | 2 | Requested group (00 G0, 01 secure G1, 10 non-secure G1) |
| sgi_ns | input | 1 | Request comes from the non-secure side |
| sec_off | input | 1 | Security disabled |
| cfg_grp | input | 32 | Group bit per interrupt |
| cfg_grpmod | input | 32 | Group modifier bit per interrupt |
| cfg_edge | input | 32 | 1 = edge-triggered, per interrupt |
| cfg_nsacc | input | 32 | 2-bit non-secure access level per software interrupt |
| pend_clr | input | 32 | Clear latched pending bits |
| pend_set | output | 32 | One-cycle pending-set strobes |
| pend_status | output | 32 | Latched pending OR live level of level-triggered lines |
| line_level | output | 32 | Stored input levels (bits 15:0 zero) |

## Verification
The bench builds the block with its defaults: 16 software interrupts and 16 peripheral lines. This keeps the access-field position of the top ID (bits 31:30) and the top peripheral ID in reach. Around the field under test, the bench fills every neighbouring group, modifier and access field with the inverse value. An off-by-one slice or index therefore flips the result.

// File: rtl/priv_pend_pkg.sv
package priv_pend_pkg;
    typedef enum logic [1:0] {
        GRP_ZERO   = 2'b00,
        GRP_ONE_S  = 2'b01,
        GRP_ONE_NS = 2'b10
    } irq_grp_e;

    function automatic irq_grp_e cfg_group(input logic grp_bit, input logic mod_bit);
        if (grp_bit)      return GRP_ONE_NS;
        else if (mod_bit) return GRP_ONE_S;
        else              return GRP_ZERO;
    endfunction
endpackage

// File: rtl/priv_line_track.sv
module priv_line_track #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] level_q,
    output logic [NUM_LINES-1:0] rise
);
    typedef struct packed {
        logic [NUM_LINES-1:0] level;
    } trk_state_t;

    trk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // only lines whose value differs from the stored copy are acted on
        for (int i = 0; i < NUM_LINES; i++) begin
            if (line_in[i] != st_q.level[i]) st_d.level[i] = line_in[i];
        end
        rise = line_in & ~st_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_q = st_q.level;
endmodule

// File: rtl/priv_sgi_gate.sv
module priv_sgi_gate
    import priv_pend_pkg::*;
#(
    parameter int NUM_SGI = 16,
    localparam int ID_W   = $clog2(NUM_SGI)
) (
    input  logic                 req_valid,
    input  logic [ID_W-1:0]      req_id,
    input  logic [1:0]           req_grp,
    input  logic                 req_ns,
    input  logic                 sec_off,
    input  logic [NUM_SGI-1:0]   grp_bits,
    input  logic [NUM_SGI-1:0]   mod_bits,
    input  logic [2*NUM_SGI-1:0] acc_bits,
    output logic [NUM_SGI-1:0]   set_vec
);
    irq_grp_e   tgt_grp;
    irq_grp_e   eff_grp;
    logic [1:0] acc_lvl;
    logic       acc_ok;

    always_comb begin
        tgt_grp = cfg_group(grp_bits[req_id], mod_bits[req_id]);
        eff_grp = irq_grp_e'(req_grp);
        if (eff_grp == GRP_ONE_S && tgt_grp == GRP_ZERO) eff_grp = GRP_ZERO;
        acc_lvl = acc_bits[2*req_id +: 2];
        acc_ok  = 1'b1;
        if (req_ns && !sec_off) begin
            if (tgt_grp == GRP_ZERO  && acc_lvl < 2'd1) acc_ok = 1'b0;
            if (tgt_grp == GRP_ONE_S && acc_lvl < 2'd2) acc_ok = 1'b0;
        end
        set_vec = '0;
        if (req_valid && eff_grp == tgt_grp && acc_ok) set_vec[req_id] = 1'b1;
    end
endmodule

// File: rtl/priv_pend_src.sv
module priv_pend_src
    import priv_pend_pkg::*;
#(
    parameter int NUM_SGI  = 16,
    parameter int NUM_PPI  = 16,
    localparam int NUM_IRQ = NUM_SGI + NUM_PPI,
    localparam int ID_W    = $clog2(NUM_SGI)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PPI-1:0]   ppi_in,
    input  logic                 sgi_valid,
    input  logic [ID_W-1:0]      sgi_id,
    input  logic [1:0]           sgi_grp,
    input  logic                 sgi_ns,
    input  logic                 sec_off,
    input  logic [NUM_IRQ-1:0]   cfg_grp,
    input  logic [NUM_IRQ-1:0]   cfg_grpmod,
    input  logic [NUM_IRQ-1:0]   cfg_edge,
    input  logic [2*NUM_SGI-1:0] cfg_nsacc,
    input  logic [NUM_IRQ-1:0]   pend_clr,
    output logic [NUM_IRQ-1:0]   pend_set,
    output logic [NUM_IRQ-1:0]   pend_status,
    output logic [NUM_IRQ-1:0]   line_level
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] latch;
        logic [NUM_IRQ-1:0] strobe;
    } pend_state_t;

    pend_state_t        st_d, st_q;
    logic [NUM_PPI-1:0] lvl_q;
    logic [NUM_PPI-1:0] lvl_rise;
    logic [NUM_SGI-1:0] sgi_set;
    logic [NUM_IRQ-1:0] set_all;

    priv_line_track #(.NUM_LINES(NUM_PPI)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (ppi_in),
        .level_q (lvl_q),
        .rise    (lvl_rise)
    );

    priv_sgi_gate #(.NUM_SGI(NUM_SGI)) u_gate (
        .req_valid (sgi_valid),
        .req_id    (sgi_id),
        .req_grp   (sgi_grp),
        .req_ns    (sgi_ns),
        .sec_off   (sec_off),
        .grp_bits  (cfg_grp[NUM_SGI-1:0]),
        .mod_bits  (cfg_grpmod[NUM_SGI-1:0]),
        .acc_bits  (cfg_nsacc),
        .set_vec   (sgi_set)
    );

    always_comb begin
        set_all = {lvl_rise & cfg_edge[NUM_IRQ-1:NUM_SGI], sgi_set};
        st_d        = st_q;
        st_d.strobe = set_all;
        // a set in the same cycle overrides a clear
        st_d.latch  = (st_q.latch & ~pend_clr) | set_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_set    = st_q.strobe;
    assign line_level  = {lvl_q, {NUM_SGI{1'b0}}};
    assign pend_status = st_q.latch | (line_level & ~cfg_edge);
endmodule

// File: rtl/priv_pend_src_chk.sv
module priv_pend_src_chk #(
    parameter int NUM_SGI  = 16,
    parameter int NUM_PPI  = 16,
    localparam int NUM_IRQ = NUM_SGI + NUM_PPI
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PPI-1:0]   ppi_in,
    input logic                 sgi_valid,
    input logic                 sgi_ns,
    input logic                 sec_off,
    input logic [NUM_IRQ-1:0]   cfg_edge,
    input logic [NUM_IRQ-1:0]   pend_set,
    input logic [NUM_IRQ-1:0]   pend_status,
    input logic [NUM_IRQ-1:0]   line_level
);
    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> line_level[NUM_IRQ-1:NUM_SGI] == $past(ppi_in)); // R1
    AST_EDGE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend_set[NUM_IRQ-1:NUM_SGI] ==
                 $past(ppi_in & ~line_level[NUM_IRQ-1:NUM_SGI] & cfg_edge[NUM_IRQ-1:NUM_SGI])); // R2
    AST_LEVEL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_set[NUM_IRQ-1:NUM_SGI] & ~$past(cfg_edge[NUM_IRQ-1:NUM_SGI])) == '0); // R3
    AST_SGI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_set[NUM_SGI-1:0])); // R7
    AST_SGI_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !sgi_valid |=> pend_set[NUM_SGI-1:0] == '0); // R7
    AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set & ~pend_status) == '0); // R9
endmodule

bind priv_pend_src priv_pend_src_chk #(.NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ppi_in      (ppi_in),
    .sgi_valid   (sgi_valid),
    .sgi_ns      (sgi_ns),
    .sec_off     (sec_off),
    .cfg_edge    (cfg_edge),
    .pend_set    (pend_set),
    .pend_status (pend_status),
    .line_level  (line_level)
);

// File: tb/priv_pend_src_bench.sv
module priv_pend_src_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ppi_in = '0;
    logic        sgi_valid = 1'b0;
    logic [3:0]  sgi_id = '0;
    logic [1:0]  sgi_grp = '0;
    logic        sgi_ns = 1'b0;
    logic        sec_off = 1'b0;
    logic [31:0] cfg_grp = '0, cfg_grpmod = '0, cfg_edge = '0, cfg_nsacc = '0, pend_clr = '0;
    logic [31:0] pend_set, pend_status, line_level;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    priv_pend_src u_priv_pend_src (
        .clk(clk), .rst_n(rst_n), .ppi_in(ppi_in), .sgi_valid(sgi_valid),
        .sgi_id(sgi_id), .sgi_grp(sgi_grp), .sgi_ns(sgi_ns), .sec_off(sec_off),
        .cfg_grp(cfg_grp), .cfg_grpmod(cfg_grpmod), .cfg_edge(cfg_edge),
        .cfg_nsacc(cfg_nsacc), .pend_clr(pend_clr), .pend_set(pend_set),
        .pend_status(pend_status), .line_level(line_level)
    );

    // {id[12:9], grp[8:7], ns[6], cfg_grp[5], cfg_mod[4], acc[3:2], sec_off[1], expect[0]}
    localparam int NV = 14;
    localparam logic [12:0] VEC [NV] = '{
        {4'd3,  2'b00, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},
        {4'd3,  2'b01, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},
        {4'd3,  2'b10, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        {4'd5,  2'b01, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1},
        {4'd5,  2'b00, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
        {4'd7,  2'b10, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1},
        {4'd7,  2'b01, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        {4'd2,  2'b00, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        {4'd2,  2'b00, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1},
        {4'd9,  2'b01, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0},
        {4'd9,  2'b01, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1},
        {4'd9,  2'b01, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1},
        {4'd15, 2'b10, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1},
        {4'd0,  2'b01, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        pend_clr = '1;
        @(negedge clk);
        pend_clr = '0;
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pend_set == 0 && pend_status == 0 && line_level == 0, "R10 reset", pend_set | pend_status | line_level, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table: software request gate (R4 R5 R6 R8 R7)
        for (int v = 0; v < NV; v++) begin
            logic [3:0] id;
            logic [31:0] exp;
            id = VEC[v][12:9];
            cfg_grp    = ~{32{VEC[v][5]}};
            cfg_grpmod = ~{32{VEC[v][4]}};
            cfg_grp[id]    = VEC[v][5];
            cfg_grpmod[id] = VEC[v][4];
            cfg_nsacc = {16{~VEC[v][3:2]}};
            cfg_nsacc[2*id +: 2] = VEC[v][3:2];
            sec_off   = VEC[v][1];
            sgi_id    = id;
            sgi_grp   = VEC[v][8:7];
            sgi_ns    = VEC[v][6];
            sgi_valid = 1'b1;
            @(negedge clk);
            sgi_valid = 1'b0;
            exp = VEC[v][0] ? (32'd1 << id) : 32'd0;
            chk(pend_set == exp, $sformatf("R5 R6 R8 R7 vector %0d", v), pend_set, exp);
            @(negedge clk);
            chk(pend_set == 0 && pend_status == exp, $sformatf("R7 latch vector %0d", v), pend_status, exp);
            clear_all();
        end
        sec_off = 1'b0; cfg_grp = '0; cfg_grpmod = '0; cfg_nsacc = '1;

        // edge-triggered line 20 (ppi bit 4)
        cfg_edge = 32'h0010_0000;
        ppi_in[4] = 1'b1;
        @(negedge clk);
        chk(pend_set == 32'h0010_0000, "R2 edge strobe", pend_set, 32'h0010_0000);
        chk(line_level == 32'h0010_0000, "R1 level stored", line_level, 32'h0010_0000);
        @(negedge clk);
        chk(pend_set == 0, "R1 steady line no strobe", pend_set, 0);
        ppi_in[4] = 1'b0;
        @(negedge clk);
        chk(pend_status == 32'h0010_0000 && line_level == 0, "R2 latched after fall", pend_status, 32'h0010_0000);
        clear_all();
        chk(pend_status == 0, "R2 cleared", pend_status, 0);

        // level-triggered line 25 (ppi bit 9)
        ppi_in[9] = 1'b1;
        @(negedge clk);
        chk(pend_set == 0, "R3 no strobe on level line", pend_set, 0);
        chk(pend_status == 32'h0200_0000, "R3 status follows level", pend_status, 32'h0200_0000);
        ppi_in[9] = 1'b0;
        @(negedge clk);
        chk(pend_status == 0, "R3 status drops with level", pend_status, 0);

        // set wins over clear, SGI id 4 group 0 secure
        sgi_id = 4'd4; sgi_grp = 2'b00; sgi_ns = 1'b0; sgi_valid = 1'b1;
        @(negedge clk);
        pend_clr = 32'h0000_0010;
        @(negedge clk);
        sgi_valid = 1'b0; pend_clr = '0;
        chk(pend_status[4] == 1'b1, "R9 set beats clear", pend_status, 32'h10);
        clear_all();

        // edge and SGI in the same cycle
        cfg_edge = 32'h8000_0000;
        ppi_in[15] = 1'b1; sgi_id = 4'd6; sgi_valid = 1'b1;
        @(negedge clk);
        sgi_valid = 1'b0;
        chk(pend_set == 32'h8000_0040, "R9 edge plus request", pend_set, 32'h8000_0040);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule